// File: doc/BRIEF.md
# Redundant Token Detector

This block is a small monitor that sits beside one pipeline stage of a handshake-driven datapath. It watches two wires: the stage's input-valid and output-valid. In a healthy stage, every new input token is followed by exactly one output token. A stage with a fault may instead produce a second output token for a single input. When the monitor sees that, it raises an alarm that stays set until reset.

Both observed wires are assumed to be already synchronous to the monitor's clock. The monitor keeps a registered copy of each wire and treats a high value with a low registered copy as a rising edge. It stays in a learning phase until it has seen a first rising edge on both wires. After that, it flags an output-valid rise that follows an earlier output-valid rise with no input-valid rise in between. The alarm is registered. It is the only output.

Top module: `rtd_monitor`

## Requirements
- R1: After a synchronous active-low reset, `alarm` is 0 and the monitor is in its learning phase. In that phase, an `out_valid` rise that is not preceded by any `in_valid` rise does not raise the alarm.
- R2: A rise is counted only in the one cycle where a sampled value of 1 follows a sampled value of 0. A wire held high for many cycles counts as a single rise.
- R3: The learning phase ends once at least one `in_valid` rise and at least one `out_valid` rise have been sampled since reset, in either order. No alarm can be raised before the learning phase ends.
- R4: After the learning phase, an `out_valid` rise raises the alarm when the most recent earlier rise event was an `out_valid` rise with no `in_valid` rise after it. The alarm reads 1 from the clock edge that samples the offending rise.
- R5: Once set, `alarm` stays 1 whatever the inputs do, until a reset returns it to 0.
- R6: An `in_valid` rise and an `out_valid` rise sampled in the same cycle count as a matched pair and never raise the alarm.
- R7: Extra `in_valid` rises with no `out_valid` rise between them never raise the alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input-valid wire of the watched stage, already synchronous |
| out_valid | input | 1 | Output-valid wire of the watched stage, already synchronous |
| alarm | output | 1 | Sticky flag: the stage emitted a surplus output token |

## Verification
Two functions can land in the same cycle: the pairing logic can consume an input rise while it also judges an output rise. The bench forces this by raising both wires on the same sampled edge, both at the end of the learning phase and in steady state. It expects no alarm in either case. Beyond those directed cases, the stimulus is random legal handshakes with occasional injected surplus output pulses, and some of those pulses are placed right after an input rise. A bench model predicts `alarm` for every cycle. The bench also checks that the alarm first appears on exactly the cycle after an injected pulse is sampled.

// File: rtl/rtd_pkg.sv
// Package: shared constants for the redundant token detector.
// Assumes: two observed wires, packed into one vector at fixed slots.
package rtd_pkg;
    localparam int unsigned NUM_WIRES = 2;
    localparam int unsigned SLOT_IN   = 0;
    localparam int unsigned SLOT_OUT  = 1;
endpackage

// File: rtl/rtd_edge_det.sv
// Module: rtd_edge_det
// Finds the rising edges of NW synchronous wires by comparing each wire
// with a registered copy of itself.
// Assumes: the wires are already synchronous to clk (no synchroniser here).
module rtd_edge_det #(
    parameter int unsigned NW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] wire_i,
    output logic [NW-1:0] rise_o
);
    logic [NW-1:0] prev_q;

    for (genvar g = 0; g < NW; g++) begin : g_lane
        // Keep last cycle's sampled value of this wire.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= wire_i[g];
        end

        // A rise is a high wire whose previous sample was low.
        always_comb rise_o[g] = wire_i[g] & ~prev_q[g];

        // A rise can never be reported in two consecutive cycles.
        assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g])
            else $error("rise reported twice in a row on lane %0d", g);
    end
endmodule

// File: rtl/rtd_pair_track.sv
// Module: rtd_pair_track
// Tracks how input and output rises pair up. It holds a learning flag
// until a first rise has been seen on each wire, and a flag recording
// that the latest rise event was an output rise. It reports a fault
// when an output rise repeats with no input rise between.
// Assumes: rise inputs are single-cycle pulses from rtd_edge_det.
module rtd_pair_track (
    input  logic clk,
    input  logic rst_n,
    input  logic in_rise_i,
    input  logic out_rise_i,
    output logic learning_o,
    output logic fault_o
);
    logic learning_q;
    logic seen_in_q;
    logic seen_out_q;
    logic out_last_q;
    logic seen_in_n;
    logic seen_out_n;

    // Accumulate the first sightings of each rise kind while learning.
    always_comb begin
        seen_in_n  = seen_in_q  | in_rise_i;
        seen_out_n = seen_out_q | out_rise_i;
    end

    // Learning flag, first-sighting flags and "output was last" flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            learning_q <= 1'b1;
            seen_in_q  <= 1'b0;
            seen_out_q <= 1'b0;
            out_last_q <= 1'b0;
        end else begin
            seen_in_q  <= seen_in_n;
            seen_out_q <= seen_out_n;
            if (learning_q && seen_in_n && seen_out_n)
                learning_q <= 1'b0;
            if (out_rise_i)
                out_last_q <= 1'b1;
            else if (in_rise_i)
                out_last_q <= 1'b0;
        end
    end

    // Surplus token: repeated output rise, no input rise since, past learning.
    always_comb fault_o = ~learning_q & out_rise_i & out_last_q & ~in_rise_i;

    assign learning_o = learning_q;

    // Once learning has ended it stays ended until reset.
    assert_learning_ends_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !learning_q |=> !learning_q)
        else $error("learning phase re-entered without reset");

    // Simultaneous input and output rises are a matched pair.
    assert_same_cycle_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rise_i && out_rise_i) |-> !fault_o)
        else $error("fault on simultaneous rises");

    // Input rises alone never produce a fault.
    assert_inputs_harmless_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_rise_i |-> !fault_o)
        else $error("fault without an output rise");
endmodule

// File: rtl/rtd_alarm_latch.sv
// Module: rtd_alarm_latch
// Registers fault pulses into a flag that holds until reset.
// Assumes: fault_i is a synchronous single-cycle indication.
module rtd_alarm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    output logic alarm_o
);
    logic alarm_q;

    // Set on any fault, clear only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       alarm_q <= 1'b0;
        else if (fault_i) alarm_q <= 1'b1;
    end

    assign alarm_o = alarm_q;

    // Sticky: a set alarm stays set.
    assert_alarm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_q |=> alarm_q)
        else $error("alarm dropped without reset");

    // A fault is reported on the following edge.
    assert_fault_reported_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> alarm_q)
        else $error("fault not latched");

    // The alarm never rises without a fault the cycle before.
    assert_no_spurious_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_q) |-> $past(fault_i))
        else $error("alarm rose without a fault");
endmodule

// File: rtl/rtd_monitor.sv
// Module: rtd_monitor (top)
// Watches a stage's input-valid and output-valid wires and raises a
// sticky alarm when the stage emits more output tokens than it took in.
// Assumes: both wires are synchronous to clk; reset is synchronous, active low.
module rtd_monitor
    import rtd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_valid,
    output logic alarm
);
    logic [NUM_WIRES-1:0] wires;
    logic [NUM_WIRES-1:0] rises;
    logic                 learning;
    logic                 fault;

    // Pack the observed wires into their fixed slots.
    always_comb begin
        wires           = '0;
        wires[SLOT_IN]  = in_valid;
        wires[SLOT_OUT] = out_valid;
    end

    rtd_edge_det #(.NW(NUM_WIRES)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .wire_i (wires),
        .rise_o (rises)
    );

    rtd_pair_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_rise_i  (rises[SLOT_IN]),
        .out_rise_i (rises[SLOT_OUT]),
        .learning_o (learning),
        .fault_o    (fault)
    );

    rtd_alarm_latch u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_i (fault),
        .alarm_o (alarm)
    );

    // The first cycle after reset shows a clear alarm and the learning phase.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!alarm && learning))
        else $error("bad state after reset");

    // No alarm while the learning phase lasts.
    assert_quiet_while_learning_R3: assert property (@(posedge clk) disable iff (!rst_n)
        learning |-> !alarm)
        else $error("alarm during learning phase");
endmodule

// File: tb/tb_rtd_monitor.sv
module tb_rtd_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic out_valid = 1'b0;
    logic alarm;

    int checks = 0;
    int errors = 0;
    int injected = 0;

    // Bench model state, built from the requirements.
    bit m_pi, m_po, m_learn, m_si, m_so, m_outlast, m_alarm;

    always #4 clk = ~clk; // 125 MHz

    rtd_monitor dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_valid (out_valid),
        .alarm     (alarm)
    );

    // Expected surplus-token verdict for one sampled cycle (R4, R6, R7).
    function automatic bit exp_fault(bit learn, bit outlast, bit ri, bit ro);
        return !learn && ro && outlast && !ri;
    endfunction

    task automatic model_reset();
        m_pi = 0; m_po = 0; m_learn = 1; m_si = 0; m_so = 0;
        m_outlast = 0; m_alarm = 0;
    endtask

    task automatic model_step(bit a, bit b);
        bit ri, ro;
        ri = a && !m_pi;
        ro = b && !m_po;
        if (exp_fault(m_learn, m_outlast, ri, ro)) m_alarm = 1;
        m_si = m_si || ri;
        m_so = m_so || ro;
        if (m_si && m_so) m_learn = 0;
        if (ro) m_outlast = 1;
        else if (ri) m_outlast = 0;
        m_pi = a;
        m_po = b;
    endtask

    task automatic check(string tag);
        checks++;
        if (alarm !== m_alarm) begin
            errors++;
            $display("FAIL %s: alarm actual %b expected %b at %0t", tag, alarm, m_alarm, $time);
        end
    endtask

    // One sampled cycle: drive at negedge, let a posedge pass, check at next negedge.
    task automatic cyc(bit a, bit b, string tag);
        in_valid = a;
        out_valid = b;
        @(posedge clk);
        model_step(a, b);
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        out_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    // A legal four-phase token with random phase lengths.
    task automatic token(string tag);
        int hi = 1 + int'($urandom_range(0, 2));
        int lo = 1 + int'($urandom_range(0, 2));
        for (int k = 0; k < hi; k++) cyc(1, 0, tag);
        for (int k = 0; k < hi; k++) cyc(1, 1, tag);
        for (int k = 0; k < lo; k++) cyc(0, 1, tag);
        for (int k = 0; k < lo; k++) cyc(0, 0, tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state");

        // R1: output pulse with no input yet stays quiet.
        cyc(0, 1, "R1 early out"); cyc(0, 0, "R1 early out");
        cyc(1, 0, "R3 learn ends"); cyc(0, 0, "R3 learn ends");
        cyc(0, 1, "R3 legal out"); cyc(0, 0, "R3 legal out");
        // R3: second surplus output after learning.
        cyc(0, 1, "R4 surplus after learn");
        if (alarm !== 1'b1) $display("FAIL R4: actual %b expected 1", alarm);

        // R2: long high levels count once.
        do_reset();
        for (int k = 0; k < 6; k++) cyc(1, 0, "R2 long in");
        for (int k = 0; k < 6; k++) cyc(1, 1, "R2 long both");
        for (int k = 0; k < 4; k++) cyc(0, 1, "R2 long out");
        cyc(0, 0, "R2 idle");
        for (int t = 0; t < 4; t++) token("R2 clean tokens");

        // R4: injected pulse raises alarm on exactly the next edge.
        cyc(0, 1, "R4 injected");
        checks++;
        if (alarm !== 1'b1) begin
            errors++;
            $display("FAIL R4 exact cycle: actual %b expected 1", alarm);
        end
        // R5: alarm holds through more traffic, then reset clears it.
        cyc(0, 0, "R5 hold");
        for (int t = 0; t < 3; t++) token("R5 hold");
        do_reset();
        check("R5 cleared by reset");

        // R6: simultaneous rises, at learning end and in steady state.
        for (int t = 0; t < 5; t++) begin
            cyc(1, 1, "R6 same cycle");
            cyc(0, 0, "R6 same cycle");
        end
        token("R6 mixed");
        cyc(1, 1, "R6 after token"); cyc(0, 0, "R6 after token");

        // R7: input rises only.
        do_reset();
        token("R7 prime");
        for (int t = 0; t < 6; t++) begin
            cyc(1, 0, "R7 inputs only");
            cyc(0, 0, "R7 inputs only");
        end
        cyc(0, 1, "R7 output after inputs"); cyc(0, 0, "R7 output after inputs");

        // Random phase: legal tokens with occasional surplus pulses.
        do_reset();
        for (int t = 0; t < 1500; t++) begin
            int pick = int'($urandom_range(0, 99));
            if (pick < 6) begin
                injected++;
                cyc(0, 1, "R4 random inject");
                cyc(0, 0, "R4 random inject");
            end else if (pick < 12) begin
                cyc(1, 0, "R4 inject after in");
                cyc(1, 1, "R4 inject after in");
                cyc(0, 0, "R4 inject after in");
                cyc(0, 1, "R4 inject after in");
                cyc(0, 0, "R4 inject after in");
            end else if (pick < 18) begin
                cyc(1, 1, "R6 random same");
                cyc(0, 0, "R6 random same");
            end else begin
                token("R2 random token");
            end
            if (m_alarm && pick > 90) do_reset();
        end
        finish_run();
    end
endmodule